// File: doc/BRIEF.md
# Shared external code/data memory port

This block lets a small microcontroller core keep its external program space and its external data space on one physical byte memory. Three requesters compete for that memory. The first is a read-only code port, used by instruction fetch and table lookup. The second is a data port that carries a full 16-bit pointer address. The third is a data port that carries only an 8-bit offset taken from a working register. For that third port, the upper address byte comes from a page register held inside the block. The block contains a single-port RAM model. Each cycle, a fixed-priority arbiter picks at most one request for it.

Both spaces are 64 KB logically. Physically, code lives in the lower half of the memory and user data in the upper half. The two logical spaces stay separate, but they share one store. A data write to a location in the code half is therefore returned by later code reads of that location. The parameter `PA_W` sizes the physical memory, and `PA_W = 16` gives the full 64 KB. The parameter `DATA_UPPER_ONLY` can confine data accesses to the upper half. Its default of 0 lets data writes patch code bytes.

Each port uses a request/ready handshake. A requester holds its request and its fields until it sees ready. Ready and read data appear combinationally in the same cycle. A write commits at the clock edge that ends its ready cycle.

Top module: `shared_xmem_port`

## Requirements
- R1: After reset, no ready output is high while its request is low, and the page register holds 0x00. A paged access with offset n therefore reaches logical address 0x00nn.
- R2: When the code request is high, code ready is high in that same cycle, and both data readies are low.
- R3: When the code request is low, the pointer data port wins over the paged data port. At most one ready is high in any cycle.
- R4: A request that loses arbitration sees ready low and makes no change to memory. It is served in the first cycle in which no higher-priority request is present.
- R5: Read data on a port is valid in the cycle its ready is high. It equals the last byte written to the mapped physical location.
- R6: Physical address = {logical[15], logical[PA_W-2:0]}. Code reads force the top physical bit to 0, so code address 0x8000+x returns the same byte as code address x.
- R7: With the default `DATA_UPPER_ONLY = 0`, a data write into the lower half is returned by a later code read of the same address.
- R8: The paged logical address is {page, offset}. When `page_we` is high, the page register loads `page_din` at the clock edge. A paged access in that same cycle still uses the old page.
- R9: A write takes effect at the edge that ends its ready cycle. Any port reading that location in the next cycle sees the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_req | input | 1 | Code read request |
| code_addr | input | 16 | Code logical address |
| code_rdy | output | 1 | Code request served this cycle |
| code_rdata | output | 8 | Code read byte, valid with code_rdy |
| dp_req | input | 1 | Pointer data request |
| dp_we | input | 1 | Pointer data write enable |
| dp_addr | input | 16 | Pointer data logical address |
| dp_wdata | input | 8 | Pointer data write byte |
| dp_rdy | output | 1 | Pointer request served this cycle |
| dp_rdata | output | 8 | Pointer read byte, valid with dp_rdy |
| pg_req | input | 1 | Paged data request |
| pg_we | input | 1 | Paged data write enable |
| pg_off | input | 8 | Paged offset (low address byte) |
| pg_wdata | input | 8 | Paged data write byte |
| pg_rdy | output | 1 | Paged request served this cycle |
| pg_rdata | output | 8 | Paged read byte, valid with pg_rdy |
| page_we | input | 1 | Load the page register |
| page_din | input | 8 | New page register value |

## Verification
A wrong grant shows up in the same cycle as a ready mismatch on one of the three ports, because readiness depends only on the requests present. A wrong page value or a wrong address fold never shows on a ready line. It appears only when a later read returns a byte from the wrong location. The bench therefore keeps a byte-level shadow of every write and compares each read it can predict in the cycle of its ready. A write committed on a stalled cycle is caught the same way, through a later read of that location.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
   typedef enum logic [1:0] {
      SRC_CODE = 2'd0,
      SRC_PTR  = 2'd1,
      SRC_PAGE = 2'd2
   } xmem_src_e;

   localparam int XMEM_NSRC = 3;

   localparam int FOLD_NONE = 0;
   localparam int FOLD_LOW  = 1;
   localparam int FOLD_HIGH = 2;
endpackage

// File: rtl/xmem_prio_arb.sv
module xmem_prio_arb #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [N-1:0] taken;

   assign taken[0] = 1'b0;

   for (genvar i = 0; i < N; i++) begin : g_lvl
      assign gnt[i] = req[i] & ~taken[i];
      if (i + 1 < N) begin : g_chain
         assign taken[i+1] = taken[i] | req[i];
      end
   end

   assert_onehot_grant_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   assert_top_wins_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      req[0] |-> gnt[0]);

   assert_grant_needs_req_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (gnt & ~req) == '0);
endmodule

// File: rtl/xmem_addr_map.sv
module xmem_addr_map #(
   parameter int LA_W = 16,
   parameter int PA_W = 11,
   parameter int FOLD = 0
) (
   input  logic [LA_W-1:0] laddr,
   output logic [PA_W-1:0] paddr
);
   logic msb;
   logic unused_laddr;

   if (FOLD == xmem_pkg::FOLD_LOW) begin : g_low
      assign msb = 1'b0;
   end else if (FOLD == xmem_pkg::FOLD_HIGH) begin : g_high
      assign msb = 1'b1;
   end else begin : g_pass
      assign msb = laddr[LA_W-1];
   end

   assign paddr        = {msb, laddr[PA_W-2:0]};
   assign unused_laddr = ^laddr;
endmodule

// File: rtl/xmem_store.sv
module xmem_store #(
   parameter int PA_W = 11,
   parameter int DW   = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [PA_W-1:0] addr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata
);
   localparam int DEPTH = 1 << PA_W;

   logic [DW-1:0] cells [0:DEPTH-1];

   always_ff @(posedge clk) begin
      if (we) cells[addr] <= wdata;
   end

   assign rdata = cells[addr];

   assert_write_visible_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (addr != $past(addr)) || (rdata == $past(wdata)));
endmodule

// File: rtl/shared_xmem_port.sv
module shared_xmem_port #(
   parameter int LA_W            = 16,
   parameter int PA_W            = 11,
   parameter int DW              = 8,
   parameter int PG_W            = 8,
   parameter bit DATA_UPPER_ONLY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 code_req,
   input  logic [LA_W-1:0]      code_addr,
   output logic                 code_rdy,
   output logic [DW-1:0]        code_rdata,
   input  logic                 dp_req,
   input  logic                 dp_we,
   input  logic [LA_W-1:0]      dp_addr,
   input  logic [DW-1:0]        dp_wdata,
   output logic                 dp_rdy,
   output logic [DW-1:0]        dp_rdata,
   input  logic                 pg_req,
   input  logic                 pg_we,
   input  logic [PG_W-1:0]      pg_off,
   input  logic [DW-1:0]        pg_wdata,
   output logic                 pg_rdy,
   output logic [DW-1:0]        pg_rdata,
   input  logic                 page_we,
   input  logic [LA_W-PG_W-1:0] page_din
);
   import xmem_pkg::*;

   localparam int HI_W  = LA_W - PG_W;
   localparam int DFOLD = DATA_UPPER_ONLY ? FOLD_HIGH : FOLD_NONE;

   if (PA_W < 2 || PA_W > LA_W) begin : g_bad_pa
      $error("PA_W must lie between 2 and LA_W");
   end
   if (PG_W < 1 || PG_W >= LA_W) begin : g_bad_pg
      $error("PG_W must be below LA_W");
   end

   logic [HI_W-1:0]      page_q;
   logic [LA_W-1:0]      pg_laddr;
   logic [PA_W-1:0]      pa [XMEM_NSRC];
   logic [XMEM_NSRC-1:0] req_v, gnt_v;
   logic                 ram_we;
   logic [PA_W-1:0]      ram_addr;
   logic [DW-1:0]        ram_wdata, ram_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n)       page_q <= '0;
      else if (page_we) page_q <= page_din;
   end

   assign pg_laddr = {page_q, pg_off};

   xmem_addr_map #(.LA_W(LA_W), .PA_W(PA_W), .FOLD(FOLD_LOW)) i_map_code (
      .laddr(code_addr), .paddr(pa[SRC_CODE]));
   xmem_addr_map #(.LA_W(LA_W), .PA_W(PA_W), .FOLD(DFOLD)) i_map_ptr (
      .laddr(dp_addr),   .paddr(pa[SRC_PTR]));
   xmem_addr_map #(.LA_W(LA_W), .PA_W(PA_W), .FOLD(DFOLD)) i_map_page (
      .laddr(pg_laddr),  .paddr(pa[SRC_PAGE]));

   assign req_v[SRC_CODE] = code_req;
   assign req_v[SRC_PTR]  = dp_req;
   assign req_v[SRC_PAGE] = pg_req;

   xmem_prio_arb #(.N(XMEM_NSRC)) i_arb (
      .clk(clk), .rst_n(rst_n), .req(req_v), .gnt(gnt_v));

   always_comb begin
      ram_we    = 1'b0;
      ram_addr  = pa[SRC_CODE];
      ram_wdata = dp_wdata;
      if (gnt_v[SRC_PTR]) begin
         ram_we    = dp_we;
         ram_addr  = pa[SRC_PTR];
         ram_wdata = dp_wdata;
      end else if (gnt_v[SRC_PAGE]) begin
         ram_we    = pg_we;
         ram_addr  = pa[SRC_PAGE];
         ram_wdata = pg_wdata;
      end
   end

   xmem_store #(.PA_W(PA_W), .DW(DW)) i_store (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .addr(ram_addr),
      .wdata(ram_wdata), .rdata(ram_rdata));

   assign code_rdy   = gnt_v[SRC_CODE];
   assign dp_rdy     = gnt_v[SRC_PTR];
   assign pg_rdy     = gnt_v[SRC_PAGE];
   assign code_rdata = ram_rdata;
   assign dp_rdata   = ram_rdata;
   assign pg_rdata   = ram_rdata;

   assert_page_load_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      page_we |=> page_q == $past(page_din));

   assert_ptr_stall_cause_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (dp_req && !dp_rdy) |-> code_req);

   assert_page_stall_cause_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (pg_req && !pg_rdy) |-> (code_req || dp_req));

   assert_code_data_exclusive_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      code_rdy |-> !(dp_rdy || pg_rdy));
endmodule

// File: tb/test_shared_xmem_port.sv
`timescale 1ns/1ps
module test_shared_xmem_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        code_req = 0, dp_req = 0, dp_we = 0, pg_req = 0, pg_we = 0, page_we = 0;
   logic [15:0] code_addr = 0, dp_addr = 0;
   logic [7:0]  dp_wdata = 0, pg_off = 0, pg_wdata = 0, page_din = 0;
   logic        code_rdy, dp_rdy, pg_rdy;
   logic [7:0]  code_rdata, dp_rdata, pg_rdata;

   int  n_chk = 0, n_err = 0;
   bit  done = 0;
   bit  c_ok = 0, p_ok = 0, g_ok = 0;
   logic [7:0] ref_mem [0:2047];
   bit         known [0:2047];
   logic [7:0] page_ref = 8'h00;

   always #5 clk = ~clk;

   shared_xmem_port i_shared_xmem_port (
      .clk(clk), .rst_n(rst_n),
      .code_req(code_req), .code_addr(code_addr), .code_rdy(code_rdy), .code_rdata(code_rdata),
      .dp_req(dp_req), .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
      .dp_rdy(dp_rdy), .dp_rdata(dp_rdata),
      .pg_req(pg_req), .pg_we(pg_we), .pg_off(pg_off), .pg_wdata(pg_wdata),
      .pg_rdy(pg_rdy), .pg_rdata(pg_rdata),
      .page_we(page_we), .page_din(page_din));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int pmap(input logic [15:0] a, input bit code);
      int base;
      base = (!code && a[15]) ? 1024 : 0;
      return base + int'(a[9:0]);
   endfunction

   function automatic logic [15:0] rnd_addr();
      logic [15:0] a;
      a = ($urandom % 2) ? 16'h8000 : 16'h0000;
      return a | 16'($urandom % 64);
   endfunction

   // Reference model: compared on every falling edge, updated on every rising edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ec, ep, eg;
         int a;
         ec = code_req;
         ep = dp_req && !code_req;
         eg = pg_req && !code_req && !dp_req;
         chk(code_rdy == ec, "R2 code_rdy", int'(code_rdy), int'(ec));
         chk(dp_rdy == ep, "R3 dp_rdy", int'(dp_rdy), int'(ep));
         chk(pg_rdy == eg, "R4 pg_rdy", int'(pg_rdy), int'(eg));
         if (ec) begin
            a = pmap(code_addr, 1'b1);
            if (known[a]) chk(code_rdata === ref_mem[a], "R5 code_rdata", int'(code_rdata), int'(ref_mem[a]));
         end
         if (ep && !dp_we) begin
            a = pmap(dp_addr, 1'b0);
            if (known[a]) chk(dp_rdata === ref_mem[a], "R5 dp_rdata", int'(dp_rdata), int'(ref_mem[a]));
         end
         if (eg && !pg_we) begin
            a = pmap({page_ref, pg_off}, 1'b0);
            if (known[a]) chk(pg_rdata === ref_mem[a], "R5 pg_rdata", int'(pg_rdata), int'(ref_mem[a]));
         end
         c_ok = code_rdy;
         p_ok = dp_rdy;
         g_ok = pg_rdy;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         page_ref <= 8'h00;
      end else begin
         if (!code_req && dp_req && dp_we) begin
            ref_mem[pmap(dp_addr, 1'b0)] <= dp_wdata;
            known[pmap(dp_addr, 1'b0)]   <= 1'b1;
         end else if (!code_req && !dp_req && pg_req && pg_we) begin
            ref_mem[pmap({page_ref, pg_off}, 1'b0)] <= pg_wdata;
            known[pmap({page_ref, pg_off}, 1'b0)]   <= 1'b1;
         end
         if (page_we) page_ref <= page_din;
      end
   end

   task automatic at_edge();
      @(posedge clk);
      #2;
   endtask

   task automatic idle();
      code_req = 0; dp_req = 0; pg_req = 0; dp_we = 0; pg_we = 0; page_we = 0;
   endtask

   task automatic report();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not complete)");
         report();
      end
   end

   initial begin
      for (int i = 0; i < 2048; i++) known[i] = 1'b0;
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R1: no ready without request after reset
      chk({code_rdy, dp_rdy, pg_rdy} == 3'b000, "R1 readies idle", int'({code_rdy, dp_rdy, pg_rdy}), 0);

      // R1: page register starts at 0x00 -> paged offset 0x12 lands at logical 0x0012
      at_edge(); pg_req = 1; pg_we = 1; pg_off = 8'h12; pg_wdata = 8'hA5;
      at_edge(); idle(); code_req = 1; code_addr = 16'h0012;
      @(negedge clk);
      chk(code_rdata == 8'hA5, "R1 reset page", int'(code_rdata), 'hA5);

      // R7: pointer write into code half, read back through code port
      at_edge(); idle(); dp_req = 1; dp_we = 1; dp_addr = 16'h0020; dp_wdata = 8'h3C;
      at_edge(); idle(); code_req = 1; code_addr = 16'h0020;
      @(negedge clk);
      chk(code_rdata == 8'h3C, "R7 code sees data write", int'(code_rdata), 'h3C);
      // R6: code address 0x8020 folds to 0x0020
      at_edge(); code_addr = 16'h8020;
      @(negedge clk);
      chk(code_rdata == 8'h3C, "R6 code fold", int'(code_rdata), 'h3C);

      // R9: upper-half write visible next cycle; R6: code still cannot reach it
      at_edge(); idle(); dp_req = 1; dp_we = 1; dp_addr = 16'h8020; dp_wdata = 8'h77;
      at_edge(); dp_we = 0;
      @(negedge clk);
      chk(dp_rdata == 8'h77, "R9 write then read", int'(dp_rdata), 'h77);
      at_edge(); idle(); code_req = 1; code_addr = 16'h8020;
      @(negedge clk);
      chk(code_rdata == 8'h3C, "R6 code stays low half", int'(code_rdata), 'h3C);

      // R2/R3/R4: three-way collision resolved over three cycles
      at_edge(); idle(); code_req = 1; code_addr = 16'h0012;
      dp_req = 1; dp_addr = 16'h8020; pg_req = 1; pg_off = 8'h20;
      @(negedge clk);
      chk({code_rdy, dp_rdy, pg_rdy} == 3'b100, "R2 code first", int'({code_rdy, dp_rdy, pg_rdy}), 'b100);
      at_edge(); code_req = 0;
      @(negedge clk);
      chk({code_rdy, dp_rdy, pg_rdy} == 3'b010, "R3 pointer before paged", int'({code_rdy, dp_rdy, pg_rdy}), 'b010);
      chk(dp_rdata == 8'h77, "R5 stalled read data", int'(dp_rdata), 'h77);
      at_edge(); dp_req = 0;
      @(negedge clk);
      chk({code_rdy, dp_rdy, pg_rdy} == 3'b001, "R4 paged served last", int'({code_rdy, dp_rdy, pg_rdy}), 'b001);

      // R4: stalled paged write must not commit while code holds the memory
      at_edge(); idle(); code_req = 1; code_addr = 16'h0005;
      pg_req = 1; pg_we = 1; pg_off = 8'h20; pg_wdata = 8'hEE;
      at_edge(); code_addr = 16'h0020;
      @(negedge clk);
      chk(code_rdata == 8'h3C, "R4 stalled write held", int'(code_rdata), 'h3C);
      at_edge(); idle();
      dp_req = 1; dp_we = 1; dp_addr = 16'h0020; dp_wdata = 8'h3C;

      // R8: page load and paged access in the same cycle uses the old page
      at_edge(); idle(); page_we = 1; page_din = 8'h80; pg_req = 1; pg_off = 8'h20;
      @(negedge clk);
      chk(pg_rdata == 8'h3C, "R8 old page in load cycle", int'(pg_rdata), 'h3C);
      at_edge(); page_we = 0;
      @(negedge clk);
      chk(pg_rdata == 8'h77, "R8 new page applied", int'(pg_rdata), 'h77);

      // Mixed traffic against the reference model (R2..R5, R9)
      at_edge(); idle();
      for (int n = 0; n < 4000; n++) begin
         at_edge();
         if (!code_req || c_ok) begin
            code_req = ($urandom % 3) == 0;
            code_addr = rnd_addr();
         end
         if (!dp_req || p_ok) begin
            dp_req = ($urandom % 2) == 0;
            dp_we = ($urandom % 2) == 0;
            dp_addr = rnd_addr();
            dp_wdata = 8'($urandom);
         end
         if (!pg_req || g_ok) begin
            pg_req = ($urandom % 2) == 0;
            pg_we = ($urandom % 2) == 0;
            pg_off = 8'($urandom % 64);
            pg_wdata = 8'($urandom);
         end
         page_we = ($urandom % 16) == 0;
         page_din = ($urandom % 2) ? 8'h80 : 8'h00;
      end
      at_edge(); idle();
      repeat (2) @(negedge clk);
      done = 1;
      report();
   end
endmodule